// File: doc/BRIEF.md
# Take-a-Ticket Crossbar Output Arbiter

This block decides which sender may connect to a crossbar output, and to which physical port. Senders share a single request bus that carries one transaction per cycle. To join the queue for a logical output, a sender issues a ticket transaction. The block answers with the next number from that output's dispenser. The sender then watches the output's published now-serving value. When that value equals its ticket, the sender issues a connect transaction. If the connect succeeds, the now-serving value moves on and the chosen physical port is marked busy. Tearing a connection down takes no bus cycle: the physical port simply pulses its done line.

A programmable table gives each physical port a logical address. Several physical ports may carry the same logical address and so form a hunt group of any size. A normal connect to a hunt group takes the lowest-numbered member that is free. A pinned connect always maps a protocol tag to the same member, which keeps a flow in order. Physical port 0 always answers to logical address 0, which is the control processor's port.

Top module: `tkt_xbar_arb`

## Requirements
- R1: When several senders drive `req_valid` in the same cycle, `bus_gnt` is one-hot on the lowest-indexed requester in that cycle. One cycle later the registered response (`rsp_valid`, `rsp_sender`) reports that transaction. With no request, the next cycle has `rsp_valid` low.
- R2: A ticket transaction (`req_op` = 0) always succeeds. `rsp_ticket` returns the addressed logical port's next-ticket count, and that count then increments. The count is 8 bits and wraps from 255 to 0.
- R3: A connect transaction (`req_op` = 1) whose `req_ticket` differs from the addressed port's now-serving count is refused (`rsp_ok` = 0). A refused connect leaves now-serving and every port busy flag unchanged.
- R4: Each logical port's now-serving count appears on `serving`. It rises by exactly 1, wrapping modulo 256, on each successful connect to that port, and at no other time.
- R5: An unpinned connect in turn goes to the lowest-indexed enabled member of the logical port's group that is not busy, and that physical index is reported on `rsp_phys`. If every member is busy, the connect is refused.
- R6: A pinned connect (`req_pin` = 1) goes to member number (`req_tag` mod group size), counting members from 0 in ascending physical index. If that member is busy, the connect is refused even when other members are free.
- R7: A successful connect sets `port_busy` of the chosen port on the same clock edge that loads the response. A `port_done` pulse clears that port's busy flag without using the bus.
- R8: A table write (`map_we`) gives physical port `map_phys` the logical address `map_lport` and sets its membership with `map_en`. The write takes effect for requests in later cycles. Writes to physical port 0 are ignored, so physical port 0 always belongs to logical port 0.
- R9: After reset, all ticket and now-serving counts are 0, no port is busy, `rsp_valid` is low, and only physical port 0 is mapped.
- R10: A connect to a logical port with no member is refused, and its now-serving count is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_SEND | Per-sender bus request |
| req_op | input | NUM_SEND | Per-sender kind: 0 ticket, 1 connect |
| req_lport | input | NUM_SEND x LW | Per-sender logical output address |
| req_ticket | input | NUM_SEND x TKT_W | Per-sender ticket held (connect) |
| req_pin | input | NUM_SEND | Per-sender pin-to-one-member flag |
| req_tag | input | NUM_SEND x TAG_W | Per-sender protocol tag for pinning |
| bus_gnt | output | NUM_SEND | One-hot bus grant, same cycle |
| rsp_valid | output | 1 | Response present |
| rsp_sender | output | SW | Index of the granted sender |
| rsp_op | output | 1 | Kind of the answered transaction |
| rsp_ok | output | 1 | Transaction accepted |
| rsp_ticket | output | TKT_W | Issued ticket, or echoed ticket for a connect |
| rsp_phys | output | PW | Physical port chosen by a successful connect |
| serving | output | NUM_LPORT x TKT_W | Now-serving count per logical port |
| port_busy | output | NUM_PHYS | Physical port connected |
| port_done | input | NUM_PHYS | Packet finished on a physical port |
| map_we | input | 1 | Table write strobe |
| map_phys | input | PW | Physical port being written |
| map_lport | input | LW | Logical address to assign |
| map_en | input | 1 | Membership enable to assign |

## Verification
The grant is combinational, so the bench checks `bus_gnt` 1 ns after it drives a request just past a falling edge. Response fields, `serving` and `port_busy` come from registers loaded on the following rising edge. They are compared at the next falling edge, one cycle after the stimulus. Table writes and done pulses are due at that same edge. The bench model therefore picks members using the busy flags and table as they stood before the edge, and only then applies the clears, the sets and the table update, which mirrors the one-cycle visibility of each result.

// File: rtl/tkt_pkg.sv
package tkt_pkg;

    typedef enum logic {
        OP_TICKET  = 1'b0,
        OP_CONNECT = 1'b1
    } tkt_op_e;

    // ceil(log2(n)) with a floor of one bit
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tkt_bus_prio.sv
module tkt_bus_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                any    = 1'b1;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tkt_counter_bank.sv
module tkt_counter_bank #(
    parameter int NL = 4,
    parameter int LW = 2,
    parameter int TW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_en,
    input  logic [LW-1:0]        issue_lp,
    input  logic                 serve_en,
    input  logic [LW-1:0]        serve_lp,
    output logic [NL-1:0][TW-1:0] next_tkt,
    output logic [NL-1:0][TW-1:0] now_srv
);
    for (genvar g = 0; g < NL; g++) begin : g_lport
        always_ff @(posedge clk) begin
            if (rst) begin
                next_tkt[g] <= '0;
            end else if (issue_en && issue_lp == LW'(g)) begin
                next_tkt[g] <= next_tkt[g] + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                now_srv[g] <= '0;
            end else if (serve_en && serve_lp == LW'(g)) begin
                now_srv[g] <= now_srv[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tkt_port_table.sv
module tkt_port_table #(
    parameter int NP = 8,
    parameter int PW = 3,
    parameter int LW = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_phys,
    input  logic [LW-1:0]         wr_lp,
    input  logic                  wr_on,
    input  logic                  grab_en,
    input  logic [PW-1:0]         grab_phys,
    input  logic [NP-1:0]         done,
    output logic [NP-1:0]         mem_on,
    output logic [NP-1:0][LW-1:0] mem_lp,
    output logic [NP-1:0]         busy
);
    for (genvar g = 0; g < NP; g++) begin : g_phys
        if (g == 0) begin : g_fixed
            assign mem_on[g] = 1'b1;
            assign mem_lp[g] = '0;
        end else begin : g_prog
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_on[g] <= 1'b0;
                    mem_lp[g] <= '0;
                end else if (wr_en && wr_phys == PW'(g)) begin
                    mem_on[g] <= wr_on;
                    mem_lp[g] <= wr_lp;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                busy[g] <= 1'b0;
            end else if (grab_en && grab_phys == PW'(g)) begin
                busy[g] <= 1'b1;
            end else if (done[g]) begin
                busy[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tkt_member_pick.sv
module tkt_member_pick #(
    parameter int NP = 8,
    parameter int PW = 3,
    parameter int LW = 2,
    parameter int GW = 4
) (
    input  logic [NP-1:0]         mem_on,
    input  logic [NP-1:0][LW-1:0] mem_lp,
    input  logic [NP-1:0]         busy,
    input  logic [LW-1:0]         lport,
    input  logic                  pin,
    input  logic [GW-1:0]         tag,
    output logic                  found,
    output logic [PW-1:0]         phys
);
    localparam int CW = $clog2(NP + 1);
    localparam int MW = (GW > CW) ? GW : CW;

    logic [CW-1:0] cnt;
    logic [CW-1:0] rank;
    logic [MW-1:0] slot;
    logic          free_ok;
    logic [PW-1:0] free_phys;
    logic          pin_ok;
    logic [PW-1:0] pin_phys;

    always_comb begin
        cnt = '0;
        for (int p = 0; p < NP; p++) begin
            if (mem_on[p] && mem_lp[p] == lport) cnt = cnt + 1'b1;
        end

        slot = (cnt == '0) ? '0 : (MW'(tag) % MW'(cnt));

        rank      = '0;
        free_ok   = 1'b0;
        free_phys = '0;
        pin_ok    = 1'b0;
        pin_phys  = '0;
        for (int p = 0; p < NP; p++) begin
            if (mem_on[p] && mem_lp[p] == lport) begin
                if (!busy[p] && !free_ok) begin
                    free_ok   = 1'b1;
                    free_phys = PW'(p);
                end
                if (MW'(rank) == slot) begin
                    pin_phys = PW'(p);
                    pin_ok   = !busy[p];
                end
                rank = rank + 1'b1;
            end
        end

        found = pin ? ((cnt != '0) && pin_ok) : free_ok;
        phys  = pin ? pin_phys : free_phys;
    end
endmodule

// File: rtl/tkt_xbar_arb.sv
module tkt_xbar_arb
    import tkt_pkg::*;
#(
    parameter int NUM_SEND  = 4,
    parameter int NUM_LPORT = 4,
    parameter int NUM_PHYS  = 8,
    parameter int TKT_W     = 8,
    parameter int TAG_W     = 4,
    localparam int SW = idx_bits(NUM_SEND),
    localparam int LW = idx_bits(NUM_LPORT),
    localparam int PW = idx_bits(NUM_PHYS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SEND-1:0]           req_valid,
    input  logic [NUM_SEND-1:0]           req_op,
    input  logic [NUM_SEND-1:0][LW-1:0]   req_lport,
    input  logic [NUM_SEND-1:0][TKT_W-1:0] req_ticket,
    input  logic [NUM_SEND-1:0]           req_pin,
    input  logic [NUM_SEND-1:0][TAG_W-1:0] req_tag,
    output logic [NUM_SEND-1:0]           bus_gnt,
    output logic                          rsp_valid,
    output logic [SW-1:0]                 rsp_sender,
    output logic                          rsp_op,
    output logic                          rsp_ok,
    output logic [TKT_W-1:0]              rsp_ticket,
    output logic [PW-1:0]                 rsp_phys,
    output logic [NUM_LPORT-1:0][TKT_W-1:0] serving,
    output logic [NUM_PHYS-1:0]           port_busy,
    input  logic [NUM_PHYS-1:0]           port_done,
    input  logic                          map_we,
    input  logic [PW-1:0]                 map_phys,
    input  logic [LW-1:0]                 map_lport,
    input  logic                          map_en
);
    logic                        bus_any;
    logic [SW-1:0]               bus_idx;
    tkt_op_e                     cur_op;
    logic [LW-1:0]               cur_lp;
    logic [TKT_W-1:0]            cur_tkt;
    logic                        cur_pin;
    logic [TAG_W-1:0]            cur_tag;
    logic [NUM_LPORT-1:0][TKT_W-1:0] next_tkt;
    logic [NUM_PHYS-1:0]         mem_on;
    logic [NUM_PHYS-1:0][LW-1:0] mem_lp;
    logic                        pick_found;
    logic [PW-1:0]               pick_phys;
    logic                        in_turn;
    logic                        issue_en;
    logic                        conn_ok;

    tkt_bus_prio #(.N(NUM_SEND), .IW(SW)) u_prio (
        .req (req_valid),
        .gnt (bus_gnt),
        .idx (bus_idx),
        .any (bus_any)
    );

    assign cur_op  = tkt_op_e'(req_op[bus_idx]);
    assign cur_lp  = req_lport[bus_idx];
    assign cur_tkt = req_ticket[bus_idx];
    assign cur_pin = req_pin[bus_idx];
    assign cur_tag = req_tag[bus_idx];

    tkt_member_pick #(.NP(NUM_PHYS), .PW(PW), .LW(LW), .GW(TAG_W)) u_pick (
        .mem_on (mem_on),
        .mem_lp (mem_lp),
        .busy   (port_busy),
        .lport  (cur_lp),
        .pin    (cur_pin),
        .tag    (cur_tag),
        .found  (pick_found),
        .phys   (pick_phys)
    );

    assign in_turn  = (cur_tkt == serving[cur_lp]);
    assign issue_en = bus_any && (cur_op == OP_TICKET);
    assign conn_ok  = bus_any && (cur_op == OP_CONNECT) && in_turn && pick_found;

    tkt_counter_bank #(.NL(NUM_LPORT), .LW(LW), .TW(TKT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .issue_en (issue_en),
        .issue_lp (cur_lp),
        .serve_en (conn_ok),
        .serve_lp (cur_lp),
        .next_tkt (next_tkt),
        .now_srv  (serving)
    );

    tkt_port_table #(.NP(NUM_PHYS), .PW(PW), .LW(LW)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (map_we),
        .wr_phys   (map_phys),
        .wr_lp     (map_lport),
        .wr_on     (map_en),
        .grab_en   (conn_ok),
        .grab_phys (pick_phys),
        .done      (port_done),
        .mem_on    (mem_on),
        .mem_lp    (mem_lp),
        .busy      (port_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_sender <= '0;
            rsp_op     <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_ticket <= '0;
            rsp_phys   <= '0;
        end else begin
            rsp_valid  <= bus_any;
            rsp_sender <= bus_idx;
            rsp_op     <= (cur_op == OP_CONNECT);
            rsp_ok     <= issue_en || conn_ok;
            rsp_ticket <= (cur_op == OP_TICKET) ? next_tkt[cur_lp] : cur_tkt;
            rsp_phys   <= conn_ok ? pick_phys : '0;
        end
    end
endmodule

// File: rtl/tkt_xbar_arb_chk.sv
module tkt_xbar_arb_chk #(
    parameter int NS = 4,
    parameter int NL = 4,
    parameter int NP = 8,
    parameter int TW = 8,
    parameter int PW = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NS-1:0]         req_valid,
    input logic [NS-1:0]         bus_gnt,
    input logic                  rsp_valid,
    input logic                  rsp_op,
    input logic                  rsp_ok,
    input logic [PW-1:0]         rsp_phys,
    input logic [NL-1:0][TW-1:0] serving,
    input logic [NP-1:0]         port_busy
);
    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_gnt) && ((bus_gnt & ~req_valid) == '0));

    // R1
    gnt_present_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |-> (|bus_gnt));

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |=> rsp_valid);

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(|req_valid) |=> !rsp_valid);

    // R2
    ticket_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_op) |-> rsp_ok);

    // R7
    conn_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_op && rsp_ok) |-> port_busy[rsp_phys]);

    for (genvar l = 0; l < NL; l++) begin : g_srv
        // R4
        srv_step_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(serving[l]) |-> (serving[l] == $past(serving[l]) + 1'b1));

        // R4
        srv_cause_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(serving[l]) |-> (rsp_valid && rsp_op && rsp_ok));
    end

    for (genvar p = 0; p < NP; p++) begin : g_busy
        // R7
        busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(port_busy[p]) |-> (rsp_valid && rsp_op && rsp_ok && rsp_phys == PW'(p)));
    end
endmodule

bind tkt_xbar_arb tkt_xbar_arb_chk #(
    .NS(NUM_SEND), .NL(NUM_LPORT), .NP(NUM_PHYS), .TW(TKT_W), .PW(PW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .bus_gnt   (bus_gnt),
    .rsp_valid (rsp_valid),
    .rsp_op    (rsp_op),
    .rsp_ok    (rsp_ok),
    .rsp_phys  (rsp_phys),
    .serving   (serving),
    .port_busy (port_busy)
);

// File: tb/tkt_xbar_arb_test.sv
module tkt_xbar_arb_test;
    localparam int S  = 4;
    localparam int L  = 4;
    localparam int P  = 8;
    localparam int TW = 8;
    localparam int GW = 4;
    localparam int SW = 2;
    localparam int LW = 2;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [S-1:0]          req_valid = '0;
    logic [S-1:0]          req_op = '0;
    logic [S-1:0][LW-1:0]  req_lport = '0;
    logic [S-1:0][TW-1:0]  req_ticket = '0;
    logic [S-1:0]          req_pin = '0;
    logic [S-1:0][GW-1:0]  req_tag = '0;
    logic [S-1:0]          bus_gnt;
    logic                  rsp_valid;
    logic [SW-1:0]         rsp_sender;
    logic                  rsp_op;
    logic                  rsp_ok;
    logic [TW-1:0]         rsp_ticket;
    logic [PW-1:0]         rsp_phys;
    logic [L-1:0][TW-1:0]  serving;
    logic [P-1:0]          port_busy;
    logic [P-1:0]          port_done = '0;
    logic                  map_we = 1'b0;
    logic [PW-1:0]         map_phys = '0;
    logic [LW-1:0]         map_lport = '0;
    logic                  map_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_tkt [L];
    int m_srv [L];
    bit m_busy[P];
    bit m_on  [P];
    int m_lp  [P];

    always #2 clk = ~clk;

    tkt_xbar_arb uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_lport(req_lport),
        .req_ticket(req_ticket), .req_pin(req_pin), .req_tag(req_tag),
        .bus_gnt(bus_gnt), .rsp_valid(rsp_valid), .rsp_sender(rsp_sender),
        .rsp_op(rsp_op), .rsp_ok(rsp_ok), .rsp_ticket(rsp_ticket),
        .rsp_phys(rsp_phys), .serving(serving), .port_busy(port_busy),
        .port_done(port_done), .map_we(map_we), .map_phys(map_phys),
        .map_lport(map_lport), .map_en(map_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // member choice from the R5/R6 rules, on the pre-edge table and busy flags
    function automatic int pick(input int l, input bit pin, input int tag, output bit found);
        int cnt = 0;
        int rank = 0;
        int slot;
        found = 1'b0;
        for (int p = 0; p < P; p++) if (m_on[p] && m_lp[p] == l) cnt++;
        if (cnt == 0) return 0;
        slot = tag % cnt;
        for (int p = 0; p < P; p++) begin
            if (m_on[p] && m_lp[p] == l) begin
                if (pin) begin
                    if (rank == slot) begin
                        found = !m_busy[p];
                        return p;
                    end
                end else if (!m_busy[p]) begin
                    found = 1'b1;
                    return p;
                end
                rank++;
            end
        end
        return 0;
    endfunction

    task automatic set_req(input int s, input bit op, input int l, input int t,
                           input bit pin, input int tag);
        req_valid[s]  = 1'b1;
        req_op[s]     = op;
        req_lport[s]  = LW'(l);
        req_ticket[s] = TW'(t);
        req_pin[s]    = pin;
        req_tag[s]    = GW'(tag);
    endtask

    // inputs are set just after a falling edge; results checked at the next one
    task automatic step();
        int  win = -1;
        bit  e_op = 1'b0;
        bit  e_ok = 1'b0;
        int  e_tkt = 0;
        int  e_phys = 0;
        int  l = 0;
        bit  found;
        int  sel;
        #1;
        for (int s = 0; s < S; s++) if (req_valid[s] && win < 0) win = s;
        // R1 grant is the lowest requester
        chk(bus_gnt == ((win < 0) ? '0 : (S'(1) << win)), "R1 grant", int'(bus_gnt), win);
        if (win >= 0) begin
            e_op = req_op[win];
            l = int'(req_lport[win]);
            if (!e_op) begin
                e_ok = 1'b1;
                e_tkt = m_tkt[l];
                m_tkt[l] = (m_tkt[l] + 1) % 256;
            end else begin
                e_tkt = int'(req_ticket[win]);
                sel = pick(l, req_pin[win], int'(req_tag[win]), found);
                e_ok = (e_tkt == m_srv[l]) && found;
                e_phys = sel;
            end
        end
        for (int p = 0; p < P; p++) if (port_done[p]) m_busy[p] = 1'b0;
        if (win >= 0 && e_op && e_ok) begin
            m_busy[e_phys] = 1'b1;
            m_srv[l] = (m_srv[l] + 1) % 256;
        end
        if (map_we && map_phys != 0) begin
            m_on[map_phys] = map_en;
            m_lp[map_phys] = int'(map_lport);
        end
        @(negedge clk);
        chk(rsp_valid == (win >= 0), "R1 rsp_valid", int'(rsp_valid), int'(win >= 0));
        if (win >= 0) begin
            chk(int'(rsp_sender) == win, "R1 rsp_sender", int'(rsp_sender), win);
            chk(rsp_op == e_op, "R3 rsp_op", int'(rsp_op), int'(e_op));
            chk(rsp_ok == e_ok, e_op ? "R3 R5 R6 R10 connect ok" : "R2 ticket ok",
                int'(rsp_ok), int'(e_ok));
            chk(int'(rsp_ticket) == e_tkt, "R2 rsp_ticket", int'(rsp_ticket), e_tkt);
            if (e_op && e_ok)
                chk(int'(rsp_phys) == e_phys, "R5 R6 rsp_phys", int'(rsp_phys), e_phys);
        end
        for (int i = 0; i < L; i++)
            chk(int'(serving[i]) == m_srv[i], "R4 serving", int'(serving[i]), m_srv[i]);
        for (int p = 0; p < P; p++)
            chk(port_busy[p] == m_busy[p], "R7 port_busy", int'(port_busy[p]), int'(m_busy[p]));
        req_valid = '0;
        port_done = '0;
        map_we    = 1'b0;
    endtask

    task automatic map_write(input int p, input int l, input bit en);
        map_we = 1'b1;
        map_phys = PW'(p);
        map_lport = LW'(l);
        map_en = en;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1d5a;
        void'($urandom(seed));
        for (int i = 0; i < L; i++) begin m_tkt[i] = 0; m_srv[i] = 0; end
        for (int p = 0; p < P; p++) begin m_busy[p] = 0; m_on[p] = (p == 0); m_lp[p] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
        chk(serving == '0, "R9 serving", int'(serving[0]), 0);
        chk(port_busy == '0, "R9 port_busy", int'(port_busy), 0);

        // R8 writing phys 0 is ignored; R10 logical 3 stays empty
        map_write(0, 3, 1'b1);
        set_req(0, 1'b0, 3, 0, 0, 0); step();
        set_req(2, 1'b1, 3, 0, 0, 0); step();           // R10 refused
        set_req(1, 1'b0, 0, 0, 0, 0); step();
        set_req(1, 1'b1, 0, 0, 0, 0); step();           // R9 R8 phys 0 answers lport 0
        port_done[0] = 1'b1; step();                     // R7 teardown without bus

        // hunt group lport1 = {1,2,3}, lport2 = {4}
        map_write(1, 1, 1'b1); map_write(2, 1, 1'b1);
        map_write(3, 1, 1'b1); map_write(4, 2, 1'b1);

        // R1 contention: senders 1..3 request together
        for (int k = 0; k < 5; k++) begin
            for (int s = 1; s < S; s++) set_req(s, 1'b0, 1, 0, 0, 0);
            step();
        end
        // R5 first free: phys 1, 2, 3 then refused
        for (int k = 0; k < 4; k++) begin set_req(0, 1'b1, 1, m_srv[1], 0, 0); step(); end
        port_done[2] = 1'b1; step();
        set_req(3, 1'b1, 1, m_srv[1], 0, 0); step();     // R5 gets phys 2
        // R3 out of turn
        set_req(0, 1'b1, 1, m_srv[1] + 1, 0, 0); step();
        port_done = 8'b0000_1110; step();
        // R6 pinned: tag 4 -> member 1 = phys 2; tag 7 -> phys 2 busy, refused
        for (int k = 0; k < 3; k++) begin set_req(0, 1'b0, 1, 0, 0, 0); step(); end
        set_req(0, 1'b1, 1, m_srv[1], 1, 4); step();
        set_req(0, 1'b1, 1, m_srv[1], 1, 7); step();
        set_req(0, 1'b1, 1, m_srv[1], 1, 9); step();     // 9 mod 3 = 0 -> phys 1

        // R2 R4 wrap past 255 on lport 2
        for (int k = 0; k < 260; k++) begin
            port_done[4] = 1'b1;
            set_req(k % S, 1'b0, 2, 0, 0, 0); step();
            set_req(0, 1'b1, 2, m_srv[2], 0, 0); step();
        end

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < S; s++) begin
                if ($urandom % 3 == 0) begin
                    int l = $urandom % L;
                    set_req(s, 1'($urandom % 2), l,
                            ($urandom % 4 != 0) ? m_srv[l] : int'($urandom % 256),
                            ($urandom % 4 == 0), int'($urandom % 16));
                end
            end
            for (int p = 0; p < P; p++) port_done[p] = ($urandom % 4 == 0);
            if ($urandom % 50 == 0) begin
                map_we = 1'b1;
                map_phys = PW'($urandom % P);
                map_lport = LW'($urandom % L);
                map_en = 1'($urandom % 2);
            end
            step();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule